// File: doc/BRIEF.md
# Nested Vectored Priority Interrupt Controller

This block sits between up to sixteen level-sensitive device request lines and a processor core. Each source has a fixed priority level, equal to its index shifted right by one, so sources pair up on eight levels and a larger level is more urgent. When the core reports that an instruction has finished, the controller chooses the most urgent eligible request. It raises a one-cycle accept pulse and presents the handler address for that source, taken from a per-source vector table.

The controller records each accepted level in an in-service bit vector. The highest set bit is the current threshold: only a request on a strictly higher level may preempt the running handler. Lower and equal levels wait. Acceptance also masks all further interrupts until the handler raises its re-enable strobe, or until an end-of-interrupt strobe retires the top level and restores the enabled state of the interrupted context. A write port programs the vector table. Entries 0 and 15 are reserved and keep their built-in addresses. After reset the vector output shows a fixed reset address that is separate from the table. Request lines are expected to be synchronous to the clock.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, take is 0, vec_addr is 16'hFFFE, in_svc is 0, interrupts are enabled, and every table entry i holds 16'h0100 + 4*i.
- R2: A request is accepted only on a clock edge where insn_done and glb_en are both 1. take goes high in the cycle after that edge and stays high for exactly one cycle.
- R3: The priority level of source i is i>>1, and a larger level wins. Among pending eligible sources on the same level, the lower index wins. take_id reports the accepted source.
- R4: An acceptance masks all further acceptances until hnd_reen or eoi is seen at a clock edge.
- R5: Accepting a source sets bit (i>>1) of in_svc. A request is eligible only if in_svc is zero or the request's level is strictly greater than the highest set in_svc bit.
- R6: eoi clears the highest set in_svc bit and re-enables interrupts. eoi with in_svc zero changes nothing in in_svc.
- R7: vec_addr shows the table entry of the accepted source in the cycle that take is high, and holds it until the next take.
- R8: A tbl_we write with tbl_idx not 0 and not 15 replaces that entry with tbl_data. Writes to index 0 or 15 are ignored. A write in the same cycle as an accept of that entry takes effect only for later accepts.
- R9: Requests are level-sensitive. A request that drops before an accepting edge is never serviced.
- R10: When eoi and an acceptance fall on the same edge, eligibility is judged against the threshold before the eoi. in_svc becomes the old vector with its top bit cleared and the new level set, and interrupts stay masked.
- R11: With glb_en low, no request is accepted, and pending requests are accepted once glb_en returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | 16 | Level-sensitive request lines, one per source |
| glb_en | input | 1 | Global interrupt enable |
| insn_done | input | 1 | Current instruction has completed this cycle |
| take | output | 1 | One-cycle accept pulse to the core |
| take_id | output | 4 | Index of the accepted source |
| vec_addr | output | 16 | Handler address of the accepted source, or the reset address |
| hnd_reen | input | 1 | Handler re-enables nesting |
| eoi | input | 1 | End of interrupt for the highest in-service level |
| in_svc | output | 8 | In-service bit per priority level |
| tbl_we | input | 1 | Vector table write strobe |
| tbl_idx | input | 4 | Vector table write index |
| tbl_data | input | 16 | Vector table write data |

## Verification
The delicate case is an end-of-interrupt that falls on the same edge as a new acceptance. Retiring the top level and pushing a new level then touch the in-service vector together, and the enable flag receives a set and a clear at once. A directed sequence provokes this. A nested handler re-enables interrupts, and a strictly higher request is then driven with insn_done and eoi on the same edge. The result is judged by take_id, by the combined in_svc value, and by a following request that must be refused because interrupts stay masked. Random traffic with frequent eoi and completion strobes hits the same overlap many more times. A cycle model of the requirements in the bench judges every cycle.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int unsigned DEF_N_SRC   = 16;
  localparam int unsigned DEF_ADDR_W  = 16;
  localparam int unsigned DEF_LVL_SH  = 1;

  // Power-on handler address of table slot idx
  function automatic logic [31:0] slot_init(input logic [31:0] base,
                                            input logic [31:0] step,
                                            input int unsigned idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned SRC_W  = 4,
  parameter int unsigned LVL_SH = 1,
  parameter int unsigned LVL_W  = 3
) (
  input  logic [N_SRC-1:0] req,
  input  logic             thr_vld,
  input  logic [LVL_W-1:0] thr_lvl,
  output logic             hit,
  output logic [SRC_W-1:0] sel_src,
  output logic [LVL_W-1:0] sel_lvl
);
  logic [N_SRC-1:0] elig;

  // A source may preempt only above the current threshold
  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    localparam logic [LVL_W-1:0] LV = LVL_W'(g >> LVL_SH);
    assign elig[g] = req[g] && (!thr_vld || (LV > thr_lvl));
  end

  // Strict compare keeps the lower index on a level tie
  always_comb begin
    hit     = 1'b0;
    sel_src = '0;
    sel_lvl = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!hit || (LVL_W'(i >> LVL_SH) > sel_lvl))) begin
        hit     = 1'b1;
        sel_src = SRC_W'(i);
        sel_lvl = LVL_W'(i >> LVL_SH);
      end
    end
  end
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int unsigned       N_SRC    = 16,
  parameter int unsigned       SRC_W    = 4,
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [31:0]       TBL_BASE = 32'h0100,
  parameter logic [31:0]       TBL_STEP = 32'h4,
  parameter logic [N_SRC-1:0]  RSV_MASK = 16'h8001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SRC_W-1:0]  widx,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [SRC_W-1:0]  ridx,
  output logic [ADDR_W-1:0] rdata
);
  import irq_nest_pkg::*;

  logic [ADDR_W-1:0] ent [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] INIT = ADDR_W'(slot_init(TBL_BASE, TBL_STEP, g));
    if (RSV_MASK[g]) begin : g_rsv
      // Reserved slot: fixed address, not writable
      assign ent[g] = INIT;
    end else begin : g_usr
      logic [ADDR_W-1:0] slot_q, slot_d;
      logic              slot_en;
      assign slot_en = we && (widx == SRC_W'(g));
      always_comb slot_d = slot_en ? wdata : slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= INIT;
        else        slot_q <= slot_d;
      end
      assign ent[g] = slot_q;
    end
  end

  assign rdata = ent[ridx];
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack #(
  parameter int unsigned N_LVL = 8,
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [N_LVL-1:0] in_svc,
  output logic             any,
  output logic [LVL_W-1:0] top_lvl
);
  logic [N_LVL-1:0] svc_q, svc_d, pop_mask, push_mask;

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (svc_q[i]) top_lvl = LVL_W'(i);
    end
  end
  assign any = |svc_q;

  always_comb begin
    pop_mask  = (pop && any) ? (N_LVL'(1) << top_lvl) : '0;
    push_mask = push ? (N_LVL'(1) << push_lvl) : '0;
    svc_d     = (svc_q & ~pop_mask) | push_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= svc_d;
  end

  assign in_svc = svc_q;

  AST_NEST_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    (push && any) |-> (push_lvl > top_lvl)) else $error("nest not strict"); // R5
  AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && any && !push) |=> ($countones(svc_q) + 1 == $countones($past(svc_q))))
    else $error("eoi did not retire one level"); // R6
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int unsigned N_SRC     = irq_nest_pkg::DEF_N_SRC,
  parameter int unsigned ADDR_W    = irq_nest_pkg::DEF_ADDR_W,
  parameter int unsigned LVL_SH    = irq_nest_pkg::DEF_LVL_SH,
  parameter logic [31:0] TBL_BASE  = 32'h0100,
  parameter logic [31:0] TBL_STEP  = 32'h4,
  parameter logic [N_SRC-1:0] RSV_MASK = 16'h8001,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'hFFFE,
  localparam int unsigned SRC_W    = $clog2(N_SRC),
  localparam int unsigned N_LVL    = N_SRC >> LVL_SH,
  localparam int unsigned LVL_W    = $clog2(N_LVL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              glb_en,
  input  logic              insn_done,
  output logic              take,
  output logic [SRC_W-1:0]  take_id,
  output logic [ADDR_W-1:0] vec_addr,
  input  logic              hnd_reen,
  input  logic              eoi,
  output logic [N_LVL-1:0]  in_svc,
  input  logic              tbl_we,
  input  logic [SRC_W-1:0]  tbl_idx,
  input  logic [ADDR_W-1:0] tbl_data
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  logic             hit, svc_any, acc;
  logic [SRC_W-1:0] sel_src;
  logic [LVL_W-1:0] sel_lvl, top_lvl;
  logic [ADDR_W-1:0] tbl_rd;

  irq_pick #(.N_SRC(N_SRC), .SRC_W(SRC_W), .LVL_SH(LVL_SH), .LVL_W(LVL_W)) u_pick (
    .req(irq_req), .thr_vld(svc_any), .thr_lvl(top_lvl),
    .hit(hit), .sel_src(sel_src), .sel_lvl(sel_lvl));

  irq_vec_table #(.N_SRC(N_SRC), .SRC_W(SRC_W), .ADDR_W(ADDR_W), .TBL_BASE(TBL_BASE),
                  .TBL_STEP(TBL_STEP), .RSV_MASK(RSV_MASK)) u_tbl (
    .clk(clk), .rst_n(rst_ns), .we(tbl_we), .widx(tbl_idx), .wdata(tbl_data),
    .ridx(sel_src), .rdata(tbl_rd));

  irq_svc_stack #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_svc (
    .clk(clk), .rst_n(rst_ns), .push(acc), .push_lvl(sel_lvl), .pop(eoi),
    .in_svc(in_svc), .any(svc_any), .top_lvl(top_lvl));

  // Accept state
  logic              ie_q, ie_d, take_q, take_d;
  logic [SRC_W-1:0]  id_q, id_d;
  logic [ADDR_W-1:0] vec_q, vec_d;

  assign acc = insn_done && glb_en && ie_q && hit;

  always_comb begin
    take_d = acc;
    id_d   = acc ? sel_src : id_q;
    vec_d  = acc ? tbl_rd  : vec_q;
    if (acc)                  ie_d = 1'b0;
    else if (eoi || hnd_reen) ie_d = 1'b1;
    else                      ie_d = ie_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ie_q   <= 1'b1;
      take_q <= 1'b0;
      id_q   <= '0;
      vec_q  <= RESET_VEC;
    end else begin
      ie_q   <= ie_d;
      take_q <= take_d;
      id_q   <= id_d;
      vec_q  <= vec_d;
    end
  end

  assign take     = take_q;
  assign take_id  = id_q;
  assign vec_addr = vec_q;

  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_ns)
    take_q |=> !take_q) else $error("take longer than one cycle"); // R2
  AST_TAKE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_ns)
    take_q |-> $past(insn_done && glb_en)) else $error("take without completion"); // R2
  AST_MASK_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_ns)
    take_q |-> !ie_q) else $error("interrupts not masked after take"); // R4
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    1'b1 |=> (take_q || $stable(vec_q))) else $error("vector moved without take"); // R7
endmodule

// File: tb/irq_nest_ctrl_bench.sv
`timescale 1ns/1ps
module irq_nest_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] req;
  logic        glb, done, reen, eoi, we;
  logic [3:0]  widx;
  logic [15:0] wdata;
  logic        take;
  logic [3:0]  take_id;
  logic [15:0] vec_addr;
  logic [7:0]  in_svc;

  always #10 clk = ~clk;

  irq_nest_ctrl u_irq_nest_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(req), .glb_en(glb), .insn_done(done),
    .take(take), .take_id(take_id), .vec_addr(vec_addr), .hnd_reen(reen), .eoi(eoi),
    .in_svc(in_svc), .tbl_we(we), .tbl_idx(widx), .tbl_data(wdata));

  int n_run = 0, n_fail = 0;

  // Requirement model
  logic [15:0] m_tbl [16];
  logic [7:0]  m_isr;
  logic        m_ie, m_take;
  logic [3:0]  m_id;
  logic [15:0] m_vec;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int best, bl, top;
    bit anyv, acc;
    anyv = (m_isr != 0);
    top = 0;
    for (int i = 0; i < 8; i++) if (m_isr[i]) top = i;
    best = -1; bl = -1;
    for (int i = 0; i < 16; i++)
      if (req[i] && (!anyv || (i >> 1) > top) && (i >> 1) > bl) begin best = i; bl = i >> 1; end
    acc = done && glb && m_ie && (best >= 0);
    m_take = acc;
    if (acc) begin m_vec = m_tbl[best]; m_id = 4'(best); end
    if (eoi && anyv) m_isr[top] = 1'b0;
    if (acc) m_isr[bl] = 1'b1;
    if (acc) m_ie = 1'b0; else if (eoi || reen) m_ie = 1'b1;
    if (we && widx != 4'd0 && widx != 4'd15) m_tbl[widx] = wdata;
  endtask

  // Apply current inputs for one edge, then compare at the falling edge
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R2", "take", take, m_take);
    chk("R7", "vec_addr", vec_addr, m_vec);
    chk("R3", "take_id", take_id, m_id);
    chk("R5", "in_svc", in_svc, m_isr);
  endtask

  task automatic idle();
    req = '0; glb = 1'b1; done = 1'b0; reen = 1'b0; eoi = 1'b0;
    we = 1'b0; widx = '0; wdata = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 16; i++) m_tbl[i] = 16'h0100 + 16'(4 * i);
    m_isr = '0; m_ie = 1'b1; m_take = 1'b0; m_id = '0; m_vec = 16'hFFFE;
  endtask

  initial begin
    #(2_000_000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'd5150);
    rst_n = 1'b0;
    do_reset();
    // R1: reset state
    chk("R1", "take", take, 0);
    chk("R1", "vec_addr", vec_addr, 16'hFFFE);
    chk("R1", "in_svc", in_svc, 0);

    // R3: tie on level 3 goes to source 6
    req = 16'h00C0; done = 1'b1; tick();
    chk("R3", "tie take_id", take_id, 6);
    chk("R1", "init slot 6", vec_addr, 16'h0118);
    do_reset();
    req = 16'h1008; done = 1'b1; tick();
    chk("R3", "level pick", take_id, 12);

    // R2: no accept while the instruction is incomplete
    do_reset();
    req = 16'h0010; done = 1'b0; tick(); tick();
    chk("R2", "no take without done", take, 0);
    done = 1'b1; tick();
    chk("R2", "take after done", take, 1);
    done = 1'b0; tick();
    chk("R2", "single pulse", take, 0);

    // R4 / R5 / R6: nesting
    do_reset();
    req = 16'h0010; done = 1'b1; tick();
    chk("R5", "level 2 in service", in_svc, 8'h04);
    req = 16'h0410; tick();
    chk("R4", "masked after accept", take, 0);
    done = 1'b0; reen = 1'b1; tick(); reen = 1'b0;
    done = 1'b1; tick();
    chk("R5", "preempt by 10", take_id, 10);
    chk("R5", "two levels", in_svc, 8'h24);
    reen = 1'b1; done = 1'b0; tick(); reen = 1'b0;
    req = 16'h0814; done = 1'b1; tick(); tick();
    chk("R5", "equal or lower blocked", take, 0);
    done = 1'b0; eoi = 1'b1; tick(); eoi = 1'b0;
    chk("R6", "top retired", in_svc, 8'h04);
    done = 1'b1; tick();
    chk("R6", "re-enabled accept", take_id, 11);

    // R10: eoi and accept on the same edge
    done = 1'b0; reen = 1'b1; tick(); reen = 1'b0;
    req = 16'h1000; done = 1'b1; eoi = 1'b1; tick(); eoi = 1'b0;
    chk("R10", "take_id", take_id, 12);
    chk("R10", "in_svc merge", in_svc, 8'h44);
    req = 16'h4000; tick();
    chk("R10", "still masked", take, 0);
    req = '0; done = 1'b0; eoi = 1'b1; tick(); tick(); tick(); eoi = 1'b0;
    chk("R6", "eoi on empty", in_svc, 0);

    // R8: table writes and reserved slots
    do_reset();
    we = 1'b1; widx = 4'd5; wdata = 16'hABCD; tick();
    widx = 4'd0; wdata = 16'h1234; tick();
    widx = 4'd15; wdata = 16'h5678; tick(); we = 1'b0;
    req = 16'h0020; done = 1'b1; tick();
    chk("R8", "written slot", vec_addr, 16'hABCD);
    req = 16'h0001; done = 1'b0; eoi = 1'b1; tick(); eoi = 1'b0;
    done = 1'b1; tick();
    chk("R8", "reserved slot 0", vec_addr, 16'h0100);
    req = 16'h8000; done = 1'b0; eoi = 1'b1; tick(); eoi = 1'b0;
    done = 1'b1; tick();
    chk("R8", "reserved slot 15", vec_addr, 16'h013C);
    // write and accept of slot 7 on the same edge
    req = 16'h0080; done = 1'b0; eoi = 1'b1; tick(); eoi = 1'b0;
    done = 1'b1; we = 1'b1; widx = 4'd7; wdata = 16'hBEEF; tick(); we = 1'b0;
    chk("R8", "old value on same edge", vec_addr, 16'h011C);

    // R9: request dropped before acceptance
    do_reset();
    req = 16'h0200; done = 1'b0; tick();
    req = '0; done = 1'b1; tick(); tick();
    chk("R9", "dropped not serviced", take, 0);
    chk("R9", "in_svc idle", in_svc, 0);

    // R11: global enable gates acceptance
    glb = 1'b0; req = 16'h0100; done = 1'b1; tick(); tick();
    chk("R11", "blocked while disabled", take, 0);
    glb = 1'b1; tick();
    chk("R11", "accepted after enable", take_id, 8);

    // Random traffic
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      req   = 16'($urandom) & 16'($urandom) & 16'($urandom);
      done  = ($urandom % 2) == 0;
      glb   = ($urandom % 10) != 0;
      reen  = ($urandom % 6) == 0;
      eoi   = ($urandom % 8) == 0;
      we    = ($urandom % 20) == 0;
      widx  = 4'($urandom);
      wdata = 16'($urandom);
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule